// File: doc/BRIEF.md
# Video Raster Timing Generator

This block keeps the horizontal and vertical position of a video raster. It runs on the system clock and moves forward only on cycles where `cyc_en` is high. The video tick rate is 11/7 of the system rate. Each enabled cycle adds 11 to a small remainder register. The tick counter then gains the whole number of sevenths, and the remainder keeps what is left over. No fraction of a tick is lost over any number of cycles.

The scanline length and the number of lines per frame follow the PAL/NTSC selection. The horizontal mode bits pick a dot-clock divider and a nominal width. The display range inputs give the visible width and height, and the visible height sets where vertical blank begins. Per-line, per-frame and blank-entry pulses drive downstream counters and the interrupt logic. A line-parity flag tells the drawing logic which field or line it is on. Mode and range inputs may change at any time; the counters keep running without a restart.

Top module: `vid_raster_timer`

## Requirements
- R1: A synchronous reset sets the following outputs to 0: tick count, scanline, the remainder, vertical blank, all pulses and the parity flag.
- R2: On a cycle with `cyc_en` high, with remainder r, the tick count grows by floor((r+11)/7) and the remainder becomes (r+11) mod 7. With `cyc_en` low, no counter, flag or pulse changes state.
- R3: The line length is 3406 ticks with 314 lines per frame when `pal` is 1, and 3413 ticks with 263 lines per frame when `pal` is 0.
- R4: The mode index is {`hres_hi`,`hres_lo`}. Index 0..7 gives `dot_div_o` = 8,4,10,5,7,7,7,7 and `nom_w_o` = 256,320,512,630,368,368,368,368.
- R5: `nom_h_o` is 480 when `interlace` and `vres` are both 1, and 240 otherwise.
- R6: `vis_w_o` = ((`x2` − `x1`) mod 2^12) / `dot_div_o`, raised to 1 if that gives 0. `vis_h_o` = (`y2` − `y1` + 1) mod 2^11.
- R7: When the advanced tick count reaches the line length, the line length is subtracted and the scanline goes up by one. `hblank_o` is high for exactly the following cycle.
- R8: When the incremented scanline reaches the lines-per-frame count, it becomes 0. `frame_o` is high for the following cycle, together with `hblank_o`.
- R9: At each line step, `vblank_o` takes the value (new scanline ≥ `vis_h_o`). `vblank_irq_o` is high for one cycle, and only when that step raises `vblank_o` from 0 to 1.
- R10: At each line step in 480-line interlaced mode, `field_o` inverts on a frame wrap and holds otherwise. In every other mode it takes bit 0 of the new scanline.
- R11: A change of mode or range takes effect on the next enabled cycle and does not reset the tick or line counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_en | input | 1 | System-cycle enable |
| hres_lo | input | 2 | Horizontal mode bits 1:0 |
| hres_hi | input | 1 | Horizontal mode bit 2 |
| vres | input | 1 | Tall-frame select |
| interlace | input | 1 | Interlace select |
| pal | input | 1 | PAL (1) or NTSC (0) line timing |
| x1 | input | X_W | Horizontal range start |
| x2 | input | X_W | Horizontal range end |
| y1 | input | Y_W | Vertical range start |
| y2 | input | Y_W | Vertical range end |
| tick_o | output | TICK_W | Tick within current scanline |
| line_o | output | LINE_W | Current scanline |
| vblank_o | output | 1 | Vertical blank level |
| vblank_irq_o | output | 1 | One-cycle pulse on entering vertical blank |
| hblank_o | output | 1 | One-cycle pulse per line step |
| frame_o | output | 1 | One-cycle pulse per frame wrap |
| field_o | output | 1 | Line/field parity flag |
| dot_div_o | output | 4 | Dot-clock divider |
| nom_w_o | output | 10 | Nominal width |
| nom_h_o | output | 9 | Nominal height |
| vis_w_o | output | X_W | Visible width |
| vis_h_o | output | Y_W+1 | Visible height |

## Verification
Several properties are checked on every cycle:
- The tick and line counts stay below their largest limits.
- No pulse or line movement follows a cycle without `cyc_en`.
- A frame pulse always comes with a line pulse on line 0.
- The interrupt fires only on a 0-to-1 edge of blank.
- The blank level and parity bit agree with the new line after each step.

Other behaviour needs the bench's scenarios. These are the exact 11/7 remainder sequence, the exact line lengths and frame heights for each standard, and the divider and width tables. They also include the parity toggle across interlaced frames and a switch from NTSC to PAL late in a line. The bench shows these by comparing every cycle with an independent model, using one instance with shortened lines and one with the full default timing.

// File: rtl/vrt_pkg.sv
package vrt_pkg;

  typedef logic [2:0] hmode_t;

  function automatic hmode_t hmode_index(input logic [1:0] lo, input logic hi);
    return {hi, lo};
  endfunction

  function automatic logic [3:0] dot_divider(input hmode_t m);
    case (m)
      3'd0:    return 4'd8;
      3'd1:    return 4'd4;
      3'd2:    return 4'd10;
      3'd3:    return 4'd5;
      default: return 4'd7;
    endcase
  endfunction

  function automatic logic [9:0] nominal_width(input hmode_t m);
    case (m)
      3'd0:    return 10'd256;
      3'd1:    return 10'd320;
      3'd2:    return 10'd512;
      3'd3:    return 10'd630;
      default: return 10'd368;
    endcase
  endfunction

  function automatic logic [8:0] nominal_height(input logic il, input logic tall);
    return (il && tall) ? 9'd480 : 9'd240;
  endfunction

endpackage

// File: rtl/vrt_mode_decode.sv
module vrt_mode_decode #(
  parameter int NTSC_LEN   = 3413,
  parameter int NTSC_LINES = 263,
  parameter int PAL_LEN    = 3406,
  parameter int PAL_LINES  = 314,
  parameter int TICK_W     = 12,
  parameter int LINE_W     = 9,
  parameter int X_W        = 12,
  parameter int Y_W        = 10,
  parameter int VH_W       = Y_W + 1
) (
  input  logic [1:0]        hres_lo,
  input  logic              hres_hi,
  input  logic              vres,
  input  logic              interlace,
  input  logic              pal,
  input  logic [X_W-1:0]    x1,
  input  logic [X_W-1:0]    x2,
  input  logic [Y_W-1:0]    y1,
  input  logic [Y_W-1:0]    y2,
  output logic [3:0]        dot_div,
  output logic [9:0]        nom_w,
  output logic [8:0]        nom_h,
  output logic [X_W-1:0]    vis_w,
  output logic [VH_W-1:0]   vis_h,
  output logic [TICK_W-1:0] line_len,
  output logic [LINE_W-1:0] frame_lines,
  output logic              il480
);
  import vrt_pkg::*;

  function automatic logic [X_W-1:0] span_to_width(input logic [X_W-1:0] lo,
                                                    input logic [X_W-1:0] hi,
                                                    input logic [3:0]     div);
    logic [X_W-1:0] span;
    logic [X_W-1:0] q;
    span = hi - lo;
    q    = span / X_W'(div);
    return (q == '0) ? X_W'(1) : q;
  endfunction

  hmode_t mode_idx;

  always_comb begin
    mode_idx    = hmode_index(hres_lo, hres_hi);
    dot_div     = dot_divider(mode_idx);
    nom_w       = nominal_width(mode_idx);
    nom_h       = nominal_height(interlace, vres);
    il480       = interlace && vres;
    vis_w       = span_to_width(x1, x2, dot_div);
    vis_h       = VH_W'(y2) - VH_W'(y1) + VH_W'(1);
    line_len    = pal ? TICK_W'(PAL_LEN)   : TICK_W'(NTSC_LEN);
    frame_lines = pal ? LINE_W'(PAL_LINES) : LINE_W'(NTSC_LINES);
  end

endmodule

// File: rtl/vrt_tick_accum.sv
module vrt_tick_accum #(
  parameter int NUM    = 11,
  parameter int DEN    = 7,
  parameter int TICK_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_en,
  input  logic [TICK_W-1:0] line_len,
  output logic [TICK_W-1:0] tick_o,
  output logic              line_step
);
  localparam int FRAC_W = $clog2(DEN);
  localparam int SUM_W  = $clog2(NUM + DEN) + 1;

  logic [FRAC_W-1:0] frac_q, frac_n;
  logic [TICK_W-1:0] tick_q, tick_n, adv;
  logic [SUM_W-1:0]  acc_sum;
  logic [TICK_W:0]   tick_sum;

  // NUM/DEN below two lines' worth per cycle: one boundary per cycle at most
  always_comb begin
    acc_sum   = SUM_W'(frac_q) + SUM_W'(NUM);
    adv       = TICK_W'(acc_sum / SUM_W'(DEN));
    frac_n    = FRAC_W'(acc_sum % SUM_W'(DEN));
    tick_sum  = {1'b0, tick_q} + {1'b0, adv};
    line_step = cyc_en && (tick_sum >= {1'b0, line_len});
    tick_n    = line_step ? TICK_W'(tick_sum - {1'b0, line_len}) : TICK_W'(tick_sum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frac_q <= '0;
      tick_q <= '0;
    end else if (cyc_en) begin
      frac_q <= frac_n;
      tick_q <= tick_n;
    end
  end

  assign tick_o = tick_q;

endmodule

// File: rtl/vrt_line_ctrl.sv
module vrt_line_ctrl #(
  parameter int LINE_W = 9,
  parameter int VH_W   = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_step,
  input  logic [LINE_W-1:0] frame_lines,
  input  logic [VH_W-1:0]   vis_h,
  input  logic              il480,
  output logic [LINE_W-1:0] line_o,
  output logic              vblank_o,
  output logic              vblank_irq_o,
  output logic              hblank_o,
  output logic              frame_o,
  output logic              field_o,
  output logic              frame_wrap
);
  logic [LINE_W-1:0] line_q, line_n;
  logic [LINE_W:0]   line_inc;
  logic              vb_q, vb_n, field_q, field_n;
  logic              irq_q, hb_q, fr_q;

  always_comb begin
    line_inc   = {1'b0, line_q} + 1'b1;
    frame_wrap = line_step && (line_inc >= {1'b0, frame_lines});
    line_n     = frame_wrap ? '0 : LINE_W'(line_inc);
    vb_n       = VH_W'(line_n) >= vis_h;
    if (il480) field_n = frame_wrap ? ~field_q : field_q;
    else       field_n = line_n[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q  <= '0;
      vb_q    <= 1'b0;
      field_q <= 1'b0;
      irq_q   <= 1'b0;
      hb_q    <= 1'b0;
      fr_q    <= 1'b0;
    end else begin
      hb_q  <= line_step;
      fr_q  <= frame_wrap;
      irq_q <= line_step && vb_n && !vb_q;
      if (line_step) begin
        line_q  <= line_n;
        vb_q    <= vb_n;
        field_q <= field_n;
      end
    end
  end

  assign line_o       = line_q;
  assign vblank_o     = vb_q;
  assign vblank_irq_o = irq_q;
  assign hblank_o     = hb_q;
  assign frame_o      = fr_q;
  assign field_o      = field_q;

endmodule

// File: rtl/vid_raster_timer.sv
module vid_raster_timer #(
  parameter int NUM        = 11,
  parameter int DEN        = 7,
  parameter int NTSC_LEN   = 3413,
  parameter int NTSC_LINES = 263,
  parameter int PAL_LEN    = 3406,
  parameter int PAL_LINES  = 314,
  parameter int TICK_W     = 12,
  parameter int LINE_W     = 9,
  parameter int X_W        = 12,
  parameter int Y_W        = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_en,
  input  logic [1:0]        hres_lo,
  input  logic              hres_hi,
  input  logic              vres,
  input  logic              interlace,
  input  logic              pal,
  input  logic [X_W-1:0]    x1,
  input  logic [X_W-1:0]    x2,
  input  logic [Y_W-1:0]    y1,
  input  logic [Y_W-1:0]    y2,
  output logic [TICK_W-1:0] tick_o,
  output logic [LINE_W-1:0] line_o,
  output logic              vblank_o,
  output logic              vblank_irq_o,
  output logic              hblank_o,
  output logic              frame_o,
  output logic              field_o,
  output logic [3:0]        dot_div_o,
  output logic [9:0]        nom_w_o,
  output logic [8:0]        nom_h_o,
  output logic [X_W-1:0]    vis_w_o,
  output logic [Y_W:0]      vis_h_o
);
  localparam int VH_W      = Y_W + 1;
  localparam int MAX_LEN   = (NTSC_LEN > PAL_LEN) ? NTSC_LEN : PAL_LEN;
  localparam int MAX_LINES = (NTSC_LINES > PAL_LINES) ? NTSC_LINES : PAL_LINES;

  // internal events, named for the bound checker
  logic [TICK_W-1:0] line_len;
  logic [LINE_W-1:0] frame_lines;
  logic              il480;
  logic              line_step;
  logic              frame_wrap;

  vrt_mode_decode #(
    .NTSC_LEN(NTSC_LEN), .NTSC_LINES(NTSC_LINES), .PAL_LEN(PAL_LEN), .PAL_LINES(PAL_LINES),
    .TICK_W(TICK_W), .LINE_W(LINE_W), .X_W(X_W), .Y_W(Y_W), .VH_W(VH_W)
  ) u_mode (
    .hres_lo(hres_lo), .hres_hi(hres_hi), .vres(vres), .interlace(interlace), .pal(pal),
    .x1(x1), .x2(x2), .y1(y1), .y2(y2),
    .dot_div(dot_div_o), .nom_w(nom_w_o), .nom_h(nom_h_o), .vis_w(vis_w_o), .vis_h(vis_h_o),
    .line_len(line_len), .frame_lines(frame_lines), .il480(il480)
  );

  vrt_tick_accum #(.NUM(NUM), .DEN(DEN), .TICK_W(TICK_W)) u_tick (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .line_len(line_len),
    .tick_o(tick_o), .line_step(line_step)
  );

  vrt_line_ctrl #(.LINE_W(LINE_W), .VH_W(VH_W)) u_line (
    .clk(clk), .rst(rst), .line_step(line_step), .frame_lines(frame_lines),
    .vis_h(vis_h_o), .il480(il480),
    .line_o(line_o), .vblank_o(vblank_o), .vblank_irq_o(vblank_irq_o),
    .hblank_o(hblank_o), .frame_o(frame_o), .field_o(field_o), .frame_wrap(frame_wrap)
  );

endmodule

// File: rtl/vrt_checker.sv
module vrt_checker #(
  parameter int TICK_W    = 12,
  parameter int LINE_W    = 9,
  parameter int X_W       = 12,
  parameter int VH_W      = 11,
  parameter int MAX_LEN   = 3413,
  parameter int MAX_LINES = 314
) (
  input logic              clk,
  input logic              rst,
  input logic              cyc_en,
  input logic              il480,
  input logic [TICK_W-1:0] tick_o,
  input logic [LINE_W-1:0] line_o,
  input logic              vblank_o,
  input logic              vblank_irq_o,
  input logic              hblank_o,
  input logic              frame_o,
  input logic              field_o,
  input logic [X_W-1:0]    vis_w_o,
  input logic [VH_W-1:0]   vis_h_o
);

  assert_tick_bound_R7: assert property (@(posedge clk) disable iff (rst)
    32'(tick_o) < MAX_LEN);

  assert_line_bound_R8: assert property (@(posedge clk) disable iff (rst)
    32'(line_o) < MAX_LINES);

  assert_idle_no_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(cyc_en) |-> !hblank_o && !frame_o && !vblank_irq_o);

  assert_idle_line_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(cyc_en) |-> $stable(line_o) && $stable(vblank_o) && $stable(field_o));

  assert_frame_on_line0_R8: assert property (@(posedge clk) disable iff (rst)
    frame_o |-> hblank_o && (line_o == '0));

  assert_irq_rise_only_R9: assert property (@(posedge clk) disable iff (rst)
    vblank_irq_o |-> vblank_o && !$past(vblank_o));

  assert_vblank_level_R9: assert property (@(posedge clk) disable iff (rst)
    hblank_o |-> vblank_o == (VH_W'(line_o) >= $past(vis_h_o)));

  assert_parity_lsb_R10: assert property (@(posedge clk) disable iff (rst)
    hblank_o && !$past(il480) |-> field_o == line_o[0]);

  always_comb begin
    if (!rst) assert_width_floor_R6: assert (vis_w_o != '0);
  end

endmodule

bind vid_raster_timer vrt_checker #(
  .TICK_W(TICK_W), .LINE_W(LINE_W), .X_W(X_W), .VH_W(VH_W),
  .MAX_LEN(MAX_LEN), .MAX_LINES(MAX_LINES)
) u_chk (
  .clk(clk), .rst(rst), .cyc_en(cyc_en), .il480(il480),
  .tick_o(tick_o), .line_o(line_o), .vblank_o(vblank_o), .vblank_irq_o(vblank_irq_o),
  .hblank_o(hblank_o), .frame_o(frame_o), .field_o(field_o),
  .vis_w_o(vis_w_o), .vis_h_o(vis_h_o)
);

// File: tb/sim_vid_raster_timer.sv
module sim_vid_raster_timer;
  localparam int S_NL = 40, S_NN = 12, S_PL = 34, S_PN = 15;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, cyc_en = 1'b0;
  logic [1:0] hres_lo = '0;
  logic hres_hi = 1'b0, vres = 1'b0, interlace = 1'b0, pal = 1'b0;
  logic [11:0] x1 = '0, x2 = '0;
  logic [9:0]  y1 = '0, y2 = '0;

  logic [11:0] a_tick, b_tick;
  logic [8:0]  a_line, b_line;
  logic a_vb, a_irq, a_hb, a_fr, a_fld, b_vb, b_irq, b_hb, b_fr, b_fld;
  logic [3:0]  a_div, b_div;
  logic [9:0]  a_nw, b_nw;
  logic [8:0]  a_nh, b_nh;
  logic [11:0] a_vw, b_vw;
  logic [10:0] a_vh, b_vh;

  vid_raster_timer #(.NTSC_LEN(S_NL), .NTSC_LINES(S_NN), .PAL_LEN(S_PL), .PAL_LINES(S_PN)) u0 (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .hres_lo(hres_lo), .hres_hi(hres_hi), .vres(vres),
    .interlace(interlace), .pal(pal), .x1(x1), .x2(x2), .y1(y1), .y2(y2),
    .tick_o(a_tick), .line_o(a_line), .vblank_o(a_vb), .vblank_irq_o(a_irq), .hblank_o(a_hb),
    .frame_o(a_fr), .field_o(a_fld), .dot_div_o(a_div), .nom_w_o(a_nw), .nom_h_o(a_nh),
    .vis_w_o(a_vw), .vis_h_o(a_vh));

  vid_raster_timer u1 (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .hres_lo(hres_lo), .hres_hi(hres_hi), .vres(vres),
    .interlace(interlace), .pal(pal), .x1(x1), .x2(x2), .y1(y1), .y2(y2),
    .tick_o(b_tick), .line_o(b_line), .vblank_o(b_vb), .vblank_irq_o(b_irq), .hblank_o(b_hb),
    .frame_o(b_fr), .field_o(b_fld), .dot_div_o(b_div), .nom_w_o(b_nw), .nom_h_o(b_nh),
    .vis_w_o(b_vw), .vis_h_o(b_vh));

  int vectors = 0, fails = 0;
  bit done = 1'b0;
  string tag = "";
  int n_frames = 0, n_irqs = 0, n_toggles = 0;

  // reference state, index 0 = u0 (short timing), 1 = u1 (full timing)
  int m_frac[2], m_tick[2], m_line[2];
  bit m_vb[2], m_irq[2], m_hb[2], m_fr[2], m_fld[2];

  function automatic int ref_div(int idx);
    int t[8] = '{8, 4, 10, 5, 7, 7, 7, 7};
    return t[idx];
  endfunction

  function automatic int ref_nomw(int idx);
    int t[8] = '{256, 320, 512, 630, 368, 368, 368, 368};
    return t[idx];
  endfunction

  function automatic int ref_visw();
    int d, q;
    d = (int'(x2) - int'(x1)) & 32'hFFF;
    q = d / ref_div({hres_hi, hres_lo});
    return (q < 1) ? 1 : q;
  endfunction

  function automatic int ref_vish();
    return (int'(y2) - int'(y1) + 1) & 32'h7FF;
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, got, exp, $time);
    end
  endtask

  task automatic step_model(input int i);
    int len, nl, tot, tsum, ln;
    bit vbn;
    len = pal ? ((i == 0) ? S_PL : 3406) : ((i == 0) ? S_NL : 3413);
    nl  = pal ? ((i == 0) ? S_PN : 314)  : ((i == 0) ? S_NN : 263);
    if (rst) begin
      m_frac[i] = 0; m_tick[i] = 0; m_line[i] = 0;
      m_vb[i] = 0; m_irq[i] = 0; m_hb[i] = 0; m_fr[i] = 0; m_fld[i] = 0;
      return;
    end
    m_hb[i] = 0; m_fr[i] = 0; m_irq[i] = 0;
    if (!cyc_en) return;
    tot = m_frac[i] + 11;
    m_frac[i] = tot % 7;
    tsum = m_tick[i] + tot / 7;
    if (tsum >= len) begin
      m_tick[i] = tsum - len;
      m_hb[i] = 1;
      ln = m_line[i] + 1;
      if (ln >= nl) begin ln = 0; m_fr[i] = 1; end
      vbn = (ln >= ref_vish());
      m_irq[i] = vbn && !m_vb[i];
      m_vb[i] = vbn;
      m_line[i] = ln;
      if (interlace && vres) begin
        if (m_fr[i]) begin m_fld[i] = !m_fld[i]; if (i == 0) n_toggles++; end
      end else m_fld[i] = ln[0];
      if (i == 0 && m_fr[i]) n_frames++;
      if (i == 0 && m_irq[i]) n_irqs++;
    end else m_tick[i] = tsum;
  endtask

  function automatic string pick(input string dflt);
    return (tag != "") ? tag : dflt;
  endfunction

  task automatic compare_inst(input int i, input int tk, input int ln, input bit vb, input bit irq,
                              input bit hb, input bit fr, input bit fld, input int dv, input int nw,
                              input int nh, input int vw, input int vh);
    int idx;
    idx = {hres_hi, hres_lo};
    chk(pick("R2"),  $sformatf("u%0d tick", i), tk, m_tick[i]);
    chk(pick("R3"),  $sformatf("u%0d line", i), ln, m_line[i]);
    chk(pick("R7"),  $sformatf("u%0d hblank", i), hb, m_hb[i]);
    chk(pick("R8"),  $sformatf("u%0d frame", i), fr, m_fr[i]);
    chk(pick("R9"),  $sformatf("u%0d vblank", i), vb, m_vb[i]);
    chk(pick("R9"),  $sformatf("u%0d irq", i), irq, m_irq[i]);
    chk(pick("R10"), $sformatf("u%0d parity", i), fld, m_fld[i]);
    chk(pick("R4"),  $sformatf("u%0d divider", i), dv, ref_div(idx));
    chk(pick("R4"),  $sformatf("u%0d nominal width", i), nw, ref_nomw(idx));
    chk(pick("R5"),  $sformatf("u%0d nominal height", i), nh, (interlace && vres) ? 480 : 240);
    chk(pick("R6"),  $sformatf("u%0d visible width", i), vw, ref_visw());
    chk(pick("R6"),  $sformatf("u%0d visible height", i), vh, ref_vish());
  endtask

  task automatic cycle();
    @(posedge clk);
    step_model(0);
    step_model(1);
    #1;
    compare_inst(0, a_tick, a_line, a_vb, a_irq, a_hb, a_fr, a_fld, a_div, a_nw, a_nh, a_vw, a_vh);
    compare_inst(1, b_tick, b_line, b_vb, b_irq, b_hb, b_fr, b_fld, b_div, b_nw, b_nh, b_vw, b_vh);
  endtask

  task automatic random_mode();
    hres_lo   = 2'($urandom % 4);
    hres_hi   = 1'($urandom % 2);
    vres      = 1'($urandom % 2);
    interlace = 1'($urandom % 2);
    pal       = 1'($urandom % 2);
    x1        = 12'($urandom % 1024);
    x2        = 12'($urandom % 4096);
    y1        = 10'($urandom % 4);
    y2        = y1 + 10'($urandom % 16);
  endtask

  task automatic run(input int n, input bit remode);
    for (int k = 0; k < n; k++) begin
      cyc_en = ($urandom % 10) != 0;
      if (remode && (k % 1500) == 0) random_mode();
      cycle();
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: reset state
    tag = "R1";
    cyc_en = 1'b1;
    repeat (3) cycle();
    rst = 1'b0;
    tag = "";

    // R4 R5 R6: every mode index and range corners with counters idle
    cyc_en = 1'b0;
    for (int idx = 0; idx < 8; idx++) begin
      hres_lo = 2'(idx); hres_hi = 1'(idx >> 2);
      vres = 1'(idx); interlace = 1'(idx >> 1);
      x1 = 12'd100; x2 = 12'd100 + 12'(idx * 300);
      cycle();
    end
    x1 = 12'd500; x2 = 12'd500; cycle();          // R6 zero span -> 1
    x1 = 12'd600; x2 = 12'd10;  cycle();          // R6 wrapped span
    y1 = 10'd9;  y2 = 10'd3;    cycle();          // R6 wrapped height
    x1 = 12'd0; x2 = 12'd2560; y1 = 10'd0; y2 = 10'd7;
    hres_lo = 2'd0; hres_hi = 1'b0; vres = 1'b0; interlace = 1'b0; pal = 1'b0;

    // R2 R7: steady NTSC, every cycle enabled
    cyc_en = 1'b1;
    repeat (400) cycle();

    // mixed random modes
    run(36000, 1'b1);

    // R10: 480-line interlaced frames on the short instance
    interlace = 1'b1; vres = 1'b1; pal = 1'b0; y1 = 10'd0; y2 = 10'd8;
    run(6000, 1'b0);
    interlace = 1'b0;
    run(600, 1'b0);

    // R11: NTSC -> PAL late in a full-length line, counters must keep running
    pal = 1'b0;
    for (int k = 0; k < 4000 && m_tick[1] < 3407; k++) begin
      cyc_en = 1'b1;
      cycle();
    end
    pal = 1'b1;
    tag = "R11";
    repeat (4) cycle();
    tag = "";
    run(3000, 1'b0);

    // R1: reset in mid-run
    tag = "R1";
    rst = 1'b1; cycle();
    rst = 1'b0; tag = "";
    run(200, 1'b0);

    chk("R8",  "frame wraps observed", int'(n_frames > 0), 1);
    chk("R9",  "blank interrupts observed", int'(n_irqs > 0), 1);
    chk("R10", "parity toggles observed", int'(n_toggles > 0), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule